// File: doc/BRIEF.md
# Random Generator Command and Status Front-End

This block is the register-level controller of a random-number engine. It sits on a simple 32-bit register bus. Software writes a command word to start a generate pass or a reseed. Two busy flags in the status register show which of the two is running. Whenever the engine is seeded and idle, software may start another pass.

A stand-in engine stands in for the real one. It is a 32-bit Galois LFSR whose reseed value comes from a free-running tick counter. Each pass takes a fixed number of cycles, set by parameters. The result lands in eight 32-bit words. A mode bit decides whether all eight words are filled or only the low four; in narrow mode the upper four read as zero.

Three events raise interrupt status bits, each cleared by writing a one to it:
- a finished generate pass,
- a finished seed,
- a lockup of the LFSR.

The `irq` output combines the pending bits with per-source enables and a global enable. A lockup is modelled by the `seu_inject` pin, which forces the LFSR to zero. A lockup drops the seeded state, so the next generate first runs a reseed. Two reload registers can also drop the seeded state:
- a count of generate passes;
- a count of cycles.

Top module: `rng_cmd_front`

## Requirements
- R1: After reset, status, interrupt status, interrupt enable, mode and all result words read 0, and `irq` is low.
- R2: Writing 32'h1 to offset 0x00 while idle and seeded sets status bit 30 for exactly GEN_CYCLES cycles. Then interrupt status bit 0 is set and the result words are refreshed.
- R3: Writing 32'h2 to offset 0x00 while idle sets status bit 31 for exactly SEED_CYCLES cycles. Then status bit 9 (seeded) and interrupt status bit 1 are set.
- R4: A generate command while unseeded first runs a full seed (bit 31, then interrupt status bit 1) and then a full generate (bit 30, then interrupt status bit 0).
- R5: A command written while status bit 30 or 31 is high is ignored. Any command value other than 1 or 2 is ignored at all times.
- R6: Mode register (0x08) bit 3 set gives eight distinct non-zero result words at 0x20..0x3C. Clear, words 4..7 read zero and words 0..3 are non-zero. Status bit 3 mirrors the mode bit.
- R7: While a generate pass runs, the result words keep their previous values.
- R8: Interrupt status (0x14) uses bit 0 for result ready, bit 1 for seed done and bit 4 for lockup. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when enable bit 31 (0x10) is set and some status bit is pending whose enable (bit 0, 1 or 4) is set.
- R10: The cycle after `seu_inject` forces the LFSR to zero while seeded, interrupt status bit 4 is set and status bit 9 clears. The next generate then reseeds first.
- R11: When the request reload at 0x60 is N (non-zero), the Nth generate completed since the last seed clears status bit 9.
- R12: When the age reload at 0x64 is A (non-zero), status bit 9 clears A cycles after a seed completes. A value of 0 disables this.
- R13: The secondary mode register (0x0C) holds bit 2 and bit 8, mirrored in status bits 2 and 8. Offset 0x00 and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high with `bus_sel` |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| seu_inject | input | 1 | Forces the LFSR state to zero (lockup model) |
| irq | output | 1 | Interrupt request |

## Verification
The reference model tracks busy flags, seeded state, interrupt status and `irq` on every clock. The bench compares status each idle cycle, so busy windows are checked to the exact cycle. Commands are tried in these situations:
- a seeded generate against an unseeded one, which tells a plain pass from the implicit seed-then-generate chain;
- commands written in the middle of a pass against unknown codes written while idle, which separates the busy guard from the code filter;
- a generate in both width modes, which shows whether the upper words are filled or zeroed.

Lockup injection, the request reload and the age reload each drop the seeded state by a different route. The bench tells them apart by when status bit 9 falls and by which interrupt bits follow.

// File: rtl/rng_cmd_front.sv
module rng_cmd_front #(
  parameter int GEN_CYCLES  = 8,
  parameter int SEED_CYCLES = 16,
  parameter int NWORDS      = 8,
  parameter int AW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          seu_inject,
  output logic          irq
);
  localparam int MAXC = (GEN_CYCLES > SEED_CYCLES) ? GEN_CYCLES : SEED_CYCLES;
  localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam int IW   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [AW-1:0] A_CMD = 'h00, A_STAT = 'h04, A_MODE = 'h08, A_SMODE = 'h0C;
  localparam logic [AW-1:0] A_IE = 'h10, A_IST = 'h14, A_RES = 'h20, A_REQ = 'h60, A_AGE = 'h64;
  localparam logic [31:0] POLY = 32'h8020_0003;
  localparam logic [31:0] MIX  = 32'h9E37_79B9;

  typedef enum logic [1:0] {S_IDLE, S_GEN, S_SEED} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           gen_after, seeded, wide, nonce, mission;
  logic [31:0]    lfsr, tick;
  logic [31:0]    res [NWORDS];
  logic [2:0]     istat;
  logic [3:0]     ie;
  logic [15:0]    req_rl, age_rl, req_cnt, age_cnt;

  wire wr       = bus_sel & bus_wr;
  wire wr_cmd   = wr && bus_addr == A_CMD;
  wire cmd_gen  = wr_cmd && bus_wdata == 32'd1 && st == S_IDLE;
  wire cmd_seed = wr_cmd && bus_wdata == 32'd2 && st == S_IDLE;
  wire gen_fin  = st == S_GEN  && cnt == '0;
  wire seed_fin = st == S_SEED && cnt == '0;
  wire lock_hit = lfsr == 32'd0 && seeded;
  wire age_exp  = !seed_fin && seeded && age_rl != 16'd0 && age_cnt <= 16'd1;
  wire req_exp  = gen_fin && req_rl != 16'd0 && ({1'b0, req_cnt} + 17'd1 >= {1'b0, req_rl});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; gen_after <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (cmd_gen && seeded) begin
            st <= S_GEN;  cnt <= CW'(GEN_CYCLES - 1);
          end else if (cmd_gen || cmd_seed) begin
            st <= S_SEED; cnt <= CW'(SEED_CYCLES - 1); gen_after <= cmd_gen;
          end
        S_GEN:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        S_SEED:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (gen_after) begin
            st <= S_GEN; cnt <= CW'(GEN_CYCLES - 1); gen_after <= 1'b0;
          end else st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0; lfsr <= '0; seeded <= 1'b0; age_cnt <= '0; req_cnt <= '0;
    end else begin
      tick <= tick + 32'd1;
      if (seed_fin)             lfsr <= (tick ^ 32'h6A09_E667) | 32'd1;
      else if (seu_inject)      lfsr <= '0;
      else if (lfsr != 32'd0)   lfsr <= {1'b0, lfsr[31:1]} ^ (lfsr[0] ? POLY : 32'd0);
      if (seed_fin)             age_cnt <= age_rl;
      else if (seeded && age_rl != 16'd0) age_cnt <= age_cnt - 16'd1;
      if (seed_fin)             req_cnt <= '0;
      else if (gen_fin && req_rl != 16'd0) req_cnt <= req_exp ? 16'd0 : req_cnt + 16'd1;
      if (seed_fin) seeded <= 1'b1;
      else if (lock_hit || age_exp || req_exp) seeded <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) res[i] <= '0;
    end else if (gen_fin) begin
      for (int i = 0; i < NWORDS; i++)
        res[i] <= (wide || i < NWORDS / 2) ? lfsr ^ (MIX * 32'(i + 1)) : 32'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      istat <= '0; ie <= '0; wide <= 1'b0; nonce <= 1'b0; mission <= 1'b0;
      req_rl <= '0; age_rl <= '0;
    end else begin
      istat <= (istat & ~((wr && bus_addr == A_IST) ? {bus_wdata[4], bus_wdata[1], bus_wdata[0]} : 3'b000))
             | {lock_hit, seed_fin, gen_fin};
      if (wr && bus_addr == A_IE)    ie <= {bus_wdata[31], bus_wdata[4], bus_wdata[1], bus_wdata[0]};
      if (wr && bus_addr == A_MODE)  wide <= bus_wdata[3];
      if (wr && bus_addr == A_SMODE) begin nonce <= bus_wdata[2]; mission <= bus_wdata[8]; end
      if (wr && bus_addr == A_REQ)   req_rl <= bus_wdata[15:0];
      if (wr && bus_addr == A_AGE)   age_rl <= bus_wdata[15:0];
    end
  end

  assign irq = ie[3] & |(istat & ie[2:0]);

  wire [AW-1:0] roff = bus_addr - A_RES;
  wire          rhit = bus_addr >= A_RES && roff[1:0] == 2'b00 && int'(roff[AW-1:2]) < NWORDS;

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {st == S_SEED, st == S_GEN, 20'd0, seeded, mission, 4'd0, wide, nonce, 2'd0};
      A_MODE:  bus_rdata = {28'd0, wide, 3'd0};
      A_SMODE: bus_rdata = {23'd0, mission, 5'd0, nonce, 2'd0};
      A_IE:    bus_rdata = {ie[3], 26'd0, ie[2], 2'd0, ie[1], ie[0]};
      A_IST:   bus_rdata = {27'd0, istat[2], 2'd0, istat[1], istat[0]};
      A_REQ:   bus_rdata = {16'd0, req_rl};
      A_AGE:   bus_rdata = {16'd0, age_rl};
      default: bus_rdata = rhit ? res[roff[IW+1:2]] : 32'd0;
    endcase
  end

  AST_RDY_AFTER_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GEN && cnt == '0) |=> istat[0] && st == S_IDLE); // R2
  AST_SEED_SETS_SEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEED && cnt == '0) |=> seeded && istat[1]); // R3
  AST_SEED_THEN_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEED && cnt == '0 && gen_after) |=> st == S_GEN); // R4
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GEN && cnt != '0 && wr_cmd) |=> st == S_GEN && cnt == $past(cnt) - 1'b1); // R5
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GEN && cnt == '0 && !wide) |=> res[NWORDS-1] == 32'd0); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GEN && cnt != '0) |=> $stable(res[0])); // R7
  AST_LOCK_UNSEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr == 32'd0 && seeded && !(st == S_SEED && cnt == '0)) |=> !seeded && istat[2]); // R10
endmodule

// File: tb/tb_rng_cmd_front.sv
module tb_rng_cmd_front;
  localparam int GEN = 8, SEED = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, seu_inject = 1'b0;
  logic [7:0] bus_addr = 8'h04;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit started = 1'b0;

  rng_cmd_front #(.GEN_CYCLES(GEN), .SEED_CYCLES(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seu_inject(seu_inject), .irq(irq));

  always #2 clk = ~clk;

  // behavioural reference model
  int m_g = 0, m_s = 0, m_age = 0, m_req = 0;
  bit m_after = 0, m_seeded = 0, m_zero = 1, m_wide = 0, m_nonce = 0, m_mission = 0;
  bit [2:0] m_ist = 0;
  bit [3:0] m_ie = 0;
  int m_areq = 0, m_aage = 0;

  function automatic logic [31:0] m_status();
    return {m_s > 0, m_g > 0, 20'd0, m_seeded, m_mission, 4'd0, m_wide, m_nonce, 2'd0};
  endfunction
  function automatic logic [31:0] m_istat_word();
    return {27'd0, m_ist[2], 2'd0, m_ist[1], m_ist[0]};
  endfunction
  function automatic bit m_irq();
    return m_ie[3] && ((m_ist & m_ie[2:0]) != 3'b000);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_g = 0; m_s = 0; m_age = 0; m_req = 0; m_after = 0; m_seeded = 0; m_zero = 1;
      m_wide = 0; m_nonce = 0; m_mission = 0; m_ist = 0; m_ie = 0; m_areq = 0; m_aage = 0;
    end else begin
      automatic bit w = bus_sel && bus_wr;
      automatic bit gfin = (m_g == 1), sfin = (m_s == 1);
      automatic bit lk = m_zero && m_seeded;
      automatic bit nseed = m_seeded;
      automatic bit idle = (m_g == 0 && m_s == 0);
      if (m_g > 0) m_g--;
      if (m_s > 0) m_s--;
      if (sfin && m_after) begin m_g = GEN; m_after = 0; end
      if (w && bus_addr == 8'h00 && idle) begin
        if (bus_wdata == 32'd1) begin
          if (m_seeded) m_g = GEN; else begin m_s = SEED; m_after = 1; end
        end else if (bus_wdata == 32'd2) m_s = SEED;
      end
      if (lk) nseed = 0;
      if (sfin) m_age = m_aage;
      else if (m_seeded && m_aage != 0) begin
        if (m_age <= 1) nseed = 0;
        m_age = (m_age - 1) & 16'hFFFF;
      end
      if (sfin) m_req = 0;
      else if (gfin && m_areq != 0) begin
        if (m_req + 1 >= m_areq) begin nseed = 0; m_req = 0; end
        else m_req++;
      end
      if (sfin) nseed = 1;
      m_seeded = nseed;
      if (sfin) m_zero = 0; else if (seu_inject) m_zero = 1;
      if (w && bus_addr == 8'h14) m_ist = m_ist & ~{bus_wdata[4], bus_wdata[1], bus_wdata[0]};
      m_ist = m_ist | {lk, sfin, gfin};
      if (w && bus_addr == 8'h10) m_ie = {bus_wdata[31], bus_wdata[4], bus_wdata[1], bus_wdata[0]};
      if (w && bus_addr == 8'h08) m_wide = bus_wdata[3];
      if (w && bus_addr == 8'h0C) begin m_nonce = bus_wdata[2]; m_mission = bus_wdata[8]; end
      if (w && bus_addr == 8'h60) m_areq = int'(bus_wdata[15:0]);
      if (w && bus_addr == 8'h64) m_aage = int'(bus_wdata[15:0]);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && rst_n) begin
    chk(irq == m_irq(), "R9 irq", 32'(irq), 32'(m_irq()));
    if (bus_addr == 8'h04)
      chk(bus_rdata == m_status(), "R2 R3 R4 R12 status per cycle", bus_rdata, m_status());
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 bus_sel = 0; bus_wr = 0; bus_addr = 8'h04; seu_inject = 0;
    end
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1 bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; seu_inject = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0; bus_addr = a; seu_inject = 0;
    @(negedge clk); v = bus_rdata;
  endtask
  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == e, tag, v, e);
  endtask
  task automatic wait_idle();
    cyc(1);
    while (m_g > 0 || m_s > 0) cyc(1);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, w0, wv [8];
    cyc(3); rst_n = 1; started = 1; cyc(1);
    rd_chk(8'h04, 32'd0, "R1 status");
    rd_chk(8'h14, 32'd0, "R1 istat");
    rd_chk(8'h10, 32'd0, "R1 ie");
    rd_chk(8'h08, 32'd0, "R1 mode");
    rd_chk(8'h3C, 32'd0, "R1 word7");
    rd_chk(8'h00, 32'd0, "R13 ctrl reads zero");
    rd_chk(8'h50, 32'd0, "R13 unmapped");
    wr(8'h10, 32'h8000_0013);
    rd_chk(8'h10, 32'h8000_0013, "R9 ie readback");
    wr(8'h00, 32'd2); wait_idle();                       // R3
    rd_chk(8'h14, 32'h2, "R3 seed done");
    rd_chk(8'h04, 32'h200, "R3 seeded");
    wr(8'h14, 32'h0); cyc(1);
    rd_chk(8'h14, 32'h2, "R8 write zero keeps");
    wr(8'h14, 32'h2); cyc(1);
    rd_chk(8'h14, 32'h0, "R8 w1c");
    // 256-bit mode, generate with busy commands ignored
    wr(8'h08, 32'h8);
    rd_chk(8'h04, 32'h208, "R6 status mirrors wide");
    wr(8'h00, 32'd1); cyc(2);
    wr(8'h00, 32'd1); wr(8'h00, 32'd2);                 // R5 ignored while busy
    rd(8'h20, w0); chk(w0 == 32'd0, "R7 word0 held during generate", w0, 32'd0);
    wait_idle(); cyc(2);
    rd_chk(8'h14, 32'h1, "R2 R5 result ready only");
    for (int i = 0; i < 8; i++) rd(8'h20 + 8'(4 * i), wv[i]);
    for (int i = 0; i < 8; i++) chk(wv[i] != 0 && (i == 0 || wv[i] != wv[i-1]), "R6 wide words", wv[i], 32'd1);
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd3); cyc(4);                            // R5 unknown code
    rd_chk(8'h14, 32'h0, "R5 unknown code ignored");
    // 128-bit mode
    wr(8'h08, 32'h0);
    wr(8'h00, 32'd1); cyc(3);
    rd(8'h20, v); chk(v == wv[0], "R7 previous value", v, wv[0]);
    wait_idle();
    for (int i = 0; i < 8; i++) begin
      rd(8'h20 + 8'(4 * i), v);
      if (i < 4) chk(v != 32'd0 && v != wv[i], "R6 narrow low words fresh", v, wv[i]);
      else chk(v == 32'd0, "R6 narrow upper zero", v, 32'd0);
    end
    // interrupt gating
    wr(8'h10, 32'h0000_0013); cyc(2);
    chk(irq == 1'b0, "R9 global off", 32'(irq), 32'd0);
    wr(8'h10, 32'h8000_0002); cyc(2);
    chk(irq == 1'b0, "R9 source masked", 32'(irq), 32'd0);
    wr(8'h10, 32'h8000_0001); cyc(2);
    chk(irq == 1'b1, "R9 source enabled", 32'(irq), 32'd1);
    wr(8'h14, 32'h1); cyc(2);
    chk(irq == 1'b0, "R8 R9 cleared", 32'(irq), 32'd0);
    wr(8'h10, 32'h8000_0013);
    wr(8'h0C, 32'h104);
    rd_chk(8'h04, 32'h304, "R13 nonce mission mirror");
    rd_chk(8'h0C, 32'h104, "R13 smode readback");
    // lockup
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0; bus_addr = 8'h04; seu_inject = 1;
    cyc(2);
    rd_chk(8'h14, 32'h10, "R10 lockup status");
    rd_chk(8'h04, 32'h104, "R10 seeded cleared");
    wr(8'h14, 32'h10);
    wr(8'h00, 32'd1); wait_idle();                       // R4 implicit reseed
    rd_chk(8'h14, 32'h3, "R4 R10 seed then generate");
    wr(8'h14, 32'h13);
    // auto request reload
    wr(8'h60, 32'd2);
    rd_chk(8'h60, 32'd2, "R11 reload readback");
    wr(8'h00, 32'd2); wait_idle();
    wr(8'h00, 32'd1); wait_idle();
    rd_chk(8'h04, 32'h304, "R11 still seeded after one");
    wr(8'h00, 32'd1); wait_idle();
    rd_chk(8'h04, 32'h104, "R11 unseeded after two");
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd1); wait_idle();
    rd_chk(8'h14, 32'h3, "R11 R4 implicit reseed");
    wr(8'h60, 32'd0); wr(8'h14, 32'h13);
    // auto age reload
    wr(8'h64, 32'd20);
    wr(8'h00, 32'd2); wait_idle();
    cyc(10);
    rd_chk(8'h04, 32'h304, "R12 seeded before age");
    cyc(15);
    rd_chk(8'h04, 32'h104, "R12 age expired");
    wr(8'h64, 32'd0);
    wr(8'h00, 32'd2); wait_idle(); cyc(40);
    rd_chk(8'h04, 32'h304, "R12 age disabled");
    cyc(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule